// File: doc/BRIEF.md
# Rangefinder Character-Pair Range Decoder

This block sits behind the serial receiver of a scanning laser rangefinder. The receiver hands it one printable character per strobe. Each distance sample travels as two such characters. Each character carries a 6-bit group raised by a fixed bias of 0x30. The decoder keeps the first character of a pair, removes the bias from both characters and joins the two groups into a 12-bit distance in millimetres, with the earlier character as the upper half. It emits that distance once per completed pair, together with the angular step index of the sample.

A scan-start pulse returns the step count to zero and drops any half-received pair. The step count then advances by one for every completed pair and wraps after one revolution of 1024 steps. A character outside the legal biased range does not decode. It discards the half-pair and raises an error flag, which stays set until reset. Downstream logic takes `distance` and `stepIdx` on the cycle where `sampleValid` pulses, for example to convert polar samples into screen coordinates.

Top module: `rangePairDecoder`

## Requirements
- R1: For a pair of legal characters c1 then c2, the reported distance equals ((c1 - 0x30) * 64) + (c2 - 0x30), so c1 supplies bits 11:6 and c2 supplies bits 5:0.
- R2: No sample is produced on the first character of a pair. `sampleValid` is high for exactly one cycle, in the cycle after the clock edge that accepts the second character.
- R3: The first pair completed after reset or after a scan start reports step index 0. Each further completed pair reports an index one higher than the previous pair.
- R4: The step index wraps from 1023 to 0.
- R5: `scanStart` clears the step count and any buffered first character. A character presented in the same cycle as `scanStart` is ignored.
- R6: Legal characters lie in 0x30..0x6F inclusive. A strobed character outside that range sets `charError`, which stays high until reset.
- R7: An illegal character discards the buffered first character, produces no sample and does not advance the step count. The next legal character starts a new pair.
- R8: `distance` and `stepIdx` hold their values in every cycle without a sample pulse.
- R9: After reset, `distance`, `stepIdx`, `sampleValid` and `charError` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| charIn | input | 8 | Received character |
| charValid | input | 1 | Qualifies `charIn` for one cycle |
| scanStart | input | 1 | Starts a new scan: clears the step count and the half-pair |
| distance | output | 12 | Decoded distance of the last sample, in mm |
| stepIdx | output | 10 | Angular step index of the last sample |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |
| charError | output | 1 | Sticky flag for an out-of-range character |

## Verification
The assertions check every cycle that the sample pulse lasts one cycle and always follows an accepted character. They also check that the outputs hold between pulses, that the step indices run in sequence from each scan start, and that an illegal character raises the error flag, which then never falls. Only the bench scenarios can show decode correctness. It sweeps all 4096 distance codes, so it covers both ends of the legal character range and several wraps of the step count. It also covers how a pair behaves across a scan start, a scan start that coincides with a character, an illegal character between pair halves, and characters arriving on back-to-back cycles.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  // Strobes from the pairing control to the datapath
  typedef struct packed {
    logic loadHigh;   // store the first group of a pair
    logic emitPair;   // merge with the second group and publish a sample
    logic clearHalf;  // drop any buffered first group
    logic clearStep;  // return the step count to zero
    logic setError;   // raise the sticky error flag
  } rpdCtrl_t;
endpackage

// File: rtl/rpd_control.sv
module rpd_control
  import rpd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     charValid,
  input  logic     scanStart,
  input  logic     charLegal,
  output rpdCtrl_t ctrl
);
  typedef enum logic { WAIT_HIGH, WAIT_LOW } pairState_t;
  pairState_t pairState;

  always_comb begin
    ctrl = '0;
    if (scanStart) begin
      ctrl.clearHalf = 1'b1;
      ctrl.clearStep = 1'b1;
    end else if (charValid) begin
      if (!charLegal) begin
        ctrl.setError  = 1'b1;
        ctrl.clearHalf = 1'b1;
      end else if (pairState == WAIT_LOW) begin
        ctrl.emitPair = 1'b1;
      end else begin
        ctrl.loadHigh = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pairState <= WAIT_HIGH;
    end else if (ctrl.clearHalf || ctrl.emitPair) begin
      pairState <= WAIT_HIGH;
    end else if (ctrl.loadHigh) begin
      pairState <= WAIT_LOW;
    end
  end
endmodule

// File: rtl/rpd_datapath.sv
module rpd_datapath
  import rpd_pkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int GROUP_W     = 6,
  parameter int STEP_W      = 10,
  parameter int CHAR_OFFSET = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHAR_W-1:0]    charIn,
  input  rpdCtrl_t             ctrl,
  output logic                 charLegal,
  output logic [2*GROUP_W-1:0] distance,
  output logic [STEP_W-1:0]    stepIdx,
  output logic                 sampleValid,
  output logic                 charError
);
  localparam logic [CHAR_W-1:0] FIRST_CHAR = CHAR_W'(CHAR_OFFSET);
  localparam logic [CHAR_W-1:0] LAST_CHAR  = CHAR_W'(CHAR_OFFSET + (1 << GROUP_W) - 1);

  logic [GROUP_W-1:0] group;
  logic [GROUP_W-1:0] highGroup;
  logic [STEP_W-1:0]  stepCount;

  assign charLegal = (charIn >= FIRST_CHAR) && (charIn <= LAST_CHAR);
  assign group     = GROUP_W'(charIn - FIRST_CHAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      highGroup   <= '0;
      stepCount   <= '0;
      distance    <= '0;
      stepIdx     <= '0;
      sampleValid <= 1'b0;
      charError   <= 1'b0;
    end else begin
      sampleValid <= ctrl.emitPair;
      if (ctrl.setError)  charError <= 1'b1;
      if (ctrl.clearHalf) highGroup <= '0;
      if (ctrl.loadHigh)  highGroup <= group;
      if (ctrl.clearStep) begin
        stepCount <= '0;
      end else if (ctrl.emitPair) begin
        stepCount <= stepCount + STEP_W'(1);
      end
      if (ctrl.emitPair) begin
        distance <= {highGroup, group};
        stepIdx  <= stepCount;
      end
    end
  end
endmodule

// File: rtl/rangePairDecoder.sv
module rangePairDecoder
  import rpd_pkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int GROUP_W     = 6,
  parameter int STEP_W      = 10,
  parameter int CHAR_OFFSET = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHAR_W-1:0]    charIn,
  input  logic                 charValid,
  input  logic                 scanStart,
  output logic [2*GROUP_W-1:0] distance,
  output logic [STEP_W-1:0]    stepIdx,
  output logic                 sampleValid,
  output logic                 charError
);
  rpdCtrl_t ctrl;
  logic     charLegal;

  rpd_control u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .charValid (charValid),
    .scanStart (scanStart),
    .charLegal (charLegal),
    .ctrl      (ctrl)
  );

  rpd_datapath #(
    .CHAR_W      (CHAR_W),
    .GROUP_W     (GROUP_W),
    .STEP_W      (STEP_W),
    .CHAR_OFFSET (CHAR_OFFSET)
  ) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .charIn      (charIn),
    .ctrl        (ctrl),
    .charLegal   (charLegal),
    .distance    (distance),
    .stepIdx     (stepIdx),
    .sampleValid (sampleValid),
    .charError   (charError)
  );
endmodule

// File: rtl/rpd_checker.sv
module rpd_checker #(
  parameter int CHAR_W      = 8,
  parameter int GROUP_W     = 6,
  parameter int STEP_W      = 10,
  parameter int CHAR_OFFSET = 48
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CHAR_W-1:0]    charIn,
  input logic                 charValid,
  input logic                 scanStart,
  input logic [2*GROUP_W-1:0] distance,
  input logic [STEP_W-1:0]    stepIdx,
  input logic                 sampleValid,
  input logic                 charError
);
  localparam int LO = CHAR_OFFSET;
  localparam int HI = CHAR_OFFSET + (1 << GROUP_W) - 1;

  logic              badChar;
  logic [STEP_W-1:0] nextStep;

  assign badChar = charValid && !scanStart &&
                   ((int'(charIn) < LO) || (int'(charIn) > HI));

  // Step index the next sample must carry
  always_ff @(posedge clk) begin
    if (!rst_n || scanStart) nextStep <= '0;
    else if (sampleValid)    nextStep <= nextStep + STEP_W'(1);
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  assert_after_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> $past(charValid && !scanStart));

  // R3 / R4: indices run in sequence and wrap
  assert_step_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> (stepIdx == nextStep));

  assert_error_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    badChar |=> charError);

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    charError |=> charError);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |-> ($stable(distance) && $stable(stepIdx)));
endmodule

bind rangePairDecoder rpd_checker #(
  .CHAR_W      (CHAR_W),
  .GROUP_W     (GROUP_W),
  .STEP_W      (STEP_W),
  .CHAR_OFFSET (CHAR_OFFSET)
) u_rpd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .charIn      (charIn),
  .charValid   (charValid),
  .scanStart   (scanStart),
  .distance    (distance),
  .stepIdx     (stepIdx),
  .sampleValid (sampleValid),
  .charError   (charError)
);

// File: tb/rangePairDecoder_bench.sv
module rangePairDecoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  charIn = 8'h00;
  logic        charValid = 1'b0;
  logic        scanStart = 1'b0;
  logic [11:0] distance;
  logic [9:0]  stepIdx;
  logic        sampleValid;
  logic        charError;

  int vectors = 0;
  int misses  = 0;
  int expStep = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rangePairDecoder u_rangePairDecoder (
    .clk(clk), .rst_n(rst_n), .charIn(charIn), .charValid(charValid),
    .scanStart(scanStart), .distance(distance), .stepIdx(stepIdx),
    .sampleValid(sampleValid), .charError(charError)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expStep = 0;
  endtask

  // One character strobed for one cycle; returns at the negedge after capture
  task automatic sendChar(input logic [7:0] c);
    @(negedge clk);
    charIn = c; charValid = 1'b1;
    @(negedge clk);
    charValid = 1'b0;
  endtask

  task automatic pulseScan();
    @(negedge clk);
    scanStart = 1'b1;
    @(negedge clk);
    scanStart = 1'b0;
    expStep = 0;
  endtask

  // Sends a pair, checks the sample, then checks that the pulse ends
  task automatic sendPair(input logic [7:0] c1, input logic [7:0] c2,
                          input string req);
    int d;
    d = ((int'(c1) - 48) * 64) + (int'(c2) - 48);
    sendChar(c1);
    check(sampleValid == 1'b0, "R2", "no sample on first char", int'(sampleValid), 0);
    sendChar(c2);
    check(sampleValid == 1'b1, "R2", "pulse after second char", int'(sampleValid), 1);
    check(distance == 12'(d), req, "distance", int'(distance), d);
    check(stepIdx == 10'(expStep), (expStep == 0) ? "R4/R3" : "R3", "step index",
          int'(stepIdx), expStep);
    expStep = (expStep + 1) % 1024;
    @(negedge clk);
    check(sampleValid == 1'b0, "R2", "pulse is one cycle", int'(sampleValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [11:0] heldD;
    logic [9:0]  heldS;
    doReset();
    @(negedge clk);
    // R9: reset state
    check(distance == 12'd0, "R9", "distance", int'(distance), 0);
    check(stepIdx == 10'd0, "R9", "stepIdx", int'(stepIdx), 0);
    check(sampleValid == 1'b0, "R9", "sampleValid", int'(sampleValid), 0);
    check(charError == 1'b0, "R9", "charError", int'(charError), 0);

    // R1, R3, R4: every distance code; the step index wraps four times
    for (int d = 0; d < 4096; d++) begin
      sendPair(8'((d >> 6) + 48), 8'((d & 63) + 48), "R1");
    end
    check(charError == 1'b0, "R6", "legal sweep keeps flag low", int'(charError), 0);

    // R8: outputs hold while idle
    heldD = distance; heldS = stepIdx;
    repeat (6) @(negedge clk);
    check(distance == heldD, "R8", "distance held", int'(distance), int'(heldD));
    check(stepIdx == heldS, "R8", "stepIdx held", int'(stepIdx), int'(heldS));

    // R5: scan start drops a half pair and restarts the count
    sendPair(8'h31, 8'h32, "R1");
    sendPair(8'h33, 8'h34, "R1");
    sendChar(8'h41);
    pulseScan();
    sendPair(8'h35, 8'h36, "R5");
    check(stepIdx == 10'd0, "R5", "step after scan start", int'(stepIdx), 0);

    // R5: a character in the same cycle as scanStart is ignored
    @(negedge clk);
    scanStart = 1'b1; charValid = 1'b1; charIn = 8'h6F;
    @(negedge clk);
    scanStart = 1'b0; charValid = 1'b0;
    expStep = 0;
    sendPair(8'h31, 8'h32, "R5");

    // R6, R7: illegal character above the range, between pair halves
    sendChar(8'h50);
    sendChar(8'h70);
    check(charError == 1'b1, "R6", "flag on 0x70", int'(charError), 1);
    check(sampleValid == 1'b0, "R7", "no sample on illegal", int'(sampleValid), 0);
    sendPair(8'h30, 8'h6F, "R7");
    // Below the range
    sendChar(8'h41);
    sendChar(8'h2F);
    check(sampleValid == 1'b0, "R7", "no sample on 0x2F", int'(sampleValid), 0);
    sendPair(8'h42, 8'h43, "R7");
    check(charError == 1'b1, "R6", "flag stays set", int'(charError), 1);
    repeat (4) @(negedge clk);
    check(charError == 1'b1, "R6", "flag sticky while idle", int'(charError), 1);
    doReset();
    @(negedge clk);
    check(charError == 1'b0, "R6", "flag cleared by reset", int'(charError), 0);

    // R2: characters on back-to-back cycles
    @(negedge clk);
    charIn = 8'h6F; charValid = 1'b1;
    @(negedge clk);
    charIn = 8'h30;
    @(negedge clk);
    charValid = 1'b0;
    check(sampleValid == 1'b1, "R2", "back-to-back pulse", int'(sampleValid), 1);
    check(distance == 12'd4032, "R1", "back-to-back distance", int'(distance), 4032);
    check(stepIdx == 10'd0, "R3", "first step after reset", int'(stepIdx), 0);
    @(negedge clk);
    check(sampleValid == 1'b0, "R2", "back-to-back pulse ends", int'(sampleValid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule